// File: doc/BRIEF.md
# Undervoltage Power-Fail Shutdown Sequencer

This controller sits between an external cell-undervoltage comparator and a battery pack's discharge switch. When the comparator reports a cell below its threshold, two deadlines start together. After the short deadline the block warns the host through an active-low power-fail line. If the undervoltage condition is still present at the long deadline, the block opens the discharge path, drops a status line and then removes bias from the monitoring circuitry.

The shutdown lasts until a wake pulse arrives. The wake closes the discharge path again, restores status and bias, and starts the warning delay from zero. If the cell recovers before the long deadline, both the warning and the pending shutdown are cancelled. While the warning is active, a host power-down request forces the shutdown at once.

Both deadlines are counted in pulses of a timebase enable. Their lengths are set by parameters, and the short one must be smaller than the long one.

Top module: `uv_shutdown_seq`

## Requirements
- R1: After reset the outputs are pf_n=1, dis_off=0, stat_ok=1 and bias_en=1.
- R2: In the running state, with the synchronised flag high, pf_n falls on the clock edge that counts the SHORT_TICKS-th tick pulse. Tick pulses can be contiguous or spaced apart.
- R3: The edge that counts the LONG_TICKS-th tick pulse raises dis_off (1 = path off) and lowers stat_ok in the same cycle.
- R4: bias_en follows the inverse of dis_off with a lag of exactly one clock.
- R5: A wake=1 sample while shut down clears dis_off, sets stat_ok and pf_n to 1, and clears the tick count.
- R6: After a wake, if the flag is still high, pf_n falls again once SHORT_TICKS further tick pulses have been counted.
- R7: When the synchronised flag is low in the running state, pf_n returns to 1 on the next edge and the count goes to zero. A later assertion therefore needs the full delays again.
- R8: host_pdn=1, sampled while pf_n=0 in the running state, raises dis_off on the next edge. host_pdn has no effect while pf_n=1. This request has priority over a low flag in the same cycle.
- R9: While shut down, uv_flag and tick have no effect until wake is sampled high.
- R10: uv_flag passes through two flops. With uv_flag raised and a tick on every clock, pf_n falls on the (2+SHORT_TICKS)-th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one pulse per delay unit |
| uv_flag | input | 1 | Asynchronous cell-undervoltage flag, high = low cell |
| wake | input | 1 | Restart request after shutdown |
| host_pdn | input | 1 | Host power-down request |
| pf_n | output | 1 | Power-fail warning, active low |
| dis_off | output | 1 | Discharge switch control, 1 = path off |
| stat_ok | output | 1 | Status, low while shut down |
| bias_en | output | 1 | Bias enable for the monitoring circuitry |

## Verification
The assertions assume that SHORT_TICKS is smaller than LONG_TICKS. This ensures that the power-fail warning is always low when the shutdown begins. They also assume that inputs change away from the clock edge. The bench drives every input on the falling edge and uses a small configuration (3 and 7 ticks) that satisfies the ordering. The bench holds uv_flag steady for at least three clocks before it depends on the synchronised value. It spaces the wake, host and flag changes so that each request is judged from one known state.

// File: rtl/uv_shutdown_seq.sv
module uv_shutdown_seq #(
  parameter int SHORT_TICKS = 200,
  parameter int LONG_TICKS  = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic uv_flag,
  input  logic wake,
  input  logic host_pdn,
  output logic pf_n,
  output logic dis_off,
  output logic stat_ok,
  output logic bias_en
);
  localparam int CW = $clog2(LONG_TICKS + 1);

  logic [1:0]    uv_sync;
  logic [CW-1:0] cnt;
  logic          shut, pf_r, bias_r;

  wire           uv_s      = uv_sync[1];
  wire [CW-1:0]  cnt_inc   = cnt + 1'b1;
  wire           hit_short = (cnt_inc == CW'(SHORT_TICKS));
  wire           hit_long  = (cnt_inc == CW'(LONG_TICKS));
  wire           force_pdn = host_pdn & ~pf_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_sync <= 2'b00;
      cnt     <= '0;
      shut    <= 1'b0;
      pf_r    <= 1'b1;
      bias_r  <= 1'b1;
    end else begin
      uv_sync <= {uv_sync[0], uv_flag};
      bias_r  <= ~shut;
      if (shut) begin
        if (wake) begin
          shut <= 1'b0;
          cnt  <= '0;
          pf_r <= 1'b1;
        end
      end else if (force_pdn) begin
        shut <= 1'b1;
      end else if (!uv_s) begin
        cnt  <= '0;
        pf_r <= 1'b1;
      end else if (tick) begin
        cnt <= cnt_inc;
        if (hit_short) pf_r <= 1'b0;
        if (hit_long)  shut <= 1'b1;
      end
    end
  end

  assign pf_n    = pf_r;
  assign dis_off = shut;
  assign stat_ok = ~shut;
  assign bias_en = bias_r;

  // R3: the shutdown is never entered while the warning is still inactive
  p_warn_before_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_off) |-> !pf_n);

  p_bias_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_off) |=> !bias_en);

  p_wake_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_off && wake) |=> (!dis_off && stat_ok && pf_n));

  p_clear_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis_off && !uv_s && !(host_pdn && !pf_n)) |=> (pf_n && !dis_off));

  p_host_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis_off && !pf_n && host_pdn) |=> dis_off);

  p_host_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis_off && pf_n) |=> !dis_off);

  p_shut_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_off && !wake) |=> (dis_off && $stable(pf_n)));
endmodule

// File: tb/test_uv_shutdown_seq.sv
module test_uv_shutdown_seq;
  localparam int SH = 3;
  localparam int LG = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, uv_flag = 1'b0, wake = 1'b0, host_pdn = 1'b0;
  logic pf_n, dis_off, stat_ok, bias_en;
  int total = 0, bad = 0, cycles = 0;

  always #10 clk = ~clk;

  uv_shutdown_seq #(.SHORT_TICKS(SH), .LONG_TICKS(LG)) i_uv_shutdown_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .uv_flag(uv_flag), .wake(wake),
    .host_pdn(host_pdn), .pf_n(pf_n), .dis_off(dis_off), .stat_ok(stat_ok),
    .bias_en(bias_en));

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t);
    tick = t;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic outs(input string req, input logic p, input logic d, input logic b);
    chk({req, " pf_n"}, pf_n, p);
    chk({req, " dis_off"}, dis_off, d);
    chk({req, " stat_ok"}, stat_ok, !d);
    chk({req, " bias_en"}, bias_en, b);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=5000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    outs("R1", 1'b1, 1'b0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    outs("R1", 1'b1, 1'b0, 1'b1);

    // R8: the request is ignored while the warning is inactive
    host_pdn = 1'b1;
    for (int i = 0; i < 3; i++) begin cyc(1'b0); chk("R8 ignored", dis_off, 1'b0); end
    host_pdn = 1'b0;

    // R10/R2/R3/R4: sweep over edges since the flag rose, one tick per clock
    uv_flag = 1'b1;
    for (int k = 1; k <= LG + 4; k++) begin
      int n;
      cyc(1'b1);
      n = (k > 2) ? k - 2 : 0;
      outs("R10/R2/R3/R4 sweep", !(n >= SH), n >= LG, !(n >= LG + 1));
    end

    // R9: flag and ticks are ignored during shutdown
    uv_flag = 1'b0;
    for (int i = 0; i < 4; i++) begin cyc(1'b1); outs("R9", 1'b0, 1'b1, 1'b0); end
    uv_flag = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b0);
    outs("R9", 1'b0, 1'b1, 1'b0);

    // R5: wake releases; R4 bias follows one clock later
    wake = 1'b1; cyc(1'b0); wake = 1'b0;
    outs("R5", 1'b1, 1'b0, 1'b0);
    cyc(1'b0);
    outs("R5/R4", 1'b1, 1'b0, 1'b1);

    // R6: the warning delay is rerun after the wake
    for (int k = 1; k <= SH + 1; k++) begin
      cyc(1'b1);
      chk("R6", pf_n, k < SH);
    end

    // R7: clearing the flag cancels the warning after the sync delay
    uv_flag = 1'b0;
    cyc(1'b1); chk("R7 sync", pf_n, 1'b0);
    cyc(1'b1); chk("R7 sync", pf_n, 1'b0);
    cyc(1'b1); chk("R7 clear", pf_n, 1'b1); chk("R7 no cut", dis_off, 1'b0);
    uv_flag = 1'b1;
    for (int k = 1; k <= LG + 1; k++) begin
      int n;
      cyc(1'b1);
      n = (k > 2) ? k - 2 : 0;
      outs("R7 restart", !(n >= SH), n >= LG, 1'b1);
    end

    // R8: the request forces shutdown while the warning is active
    host_pdn = 1'b1; cyc(1'b0); host_pdn = 1'b0;
    outs("R8 forced", 1'b0, 1'b1, 1'b1);
    cyc(1'b0);
    outs("R8/R4", 1'b0, 1'b1, 1'b0);
    wake = 1'b1; cyc(1'b0); wake = 1'b0;
    outs("R5 second", 1'b1, 1'b0, 1'b0);

    // R2: tick pulses spaced three clocks apart
    begin
      int seen = 0;
      for (int c = 1; c <= 3 * SH + 3; c++) begin
        logic t;
        t = (c % 3 == 0);
        cyc(t);
        if (t) seen++;
        chk("R2 gapped", pf_n, seen < SH);
        chk("R2 gapped dis_off", dis_off, 1'b0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule